// File: doc/BRIEF.md
# Masked vector-index prefetch address generator

This block turns one vector prefetch command into a stream of cache-prefetch request addresses. A command carries a 64-bit base, a 512-bit packed index vector, a 2-bit scale code, a signed 32-bit displacement, a 16-bit lane mask and a 2-bit variant. The variant selects the index width (32 or 64 bits) and the lane count (16 or 8). For each lane whose mask bit is set, the block computes base + sign-extended index × scale + sign-extended displacement and presents it on a valid/ready request port. Every request is marked for the second-level cache as a plain read.

The command port is valid/ready. `cmd_ready` is high only while the block is idle, and all command fields are captured on the accepting edge. The request port follows the usual back-pressure rules: once `req_valid` rises, address and lane stay frozen until `req_ready` is high at a clock edge. A one-cycle `done` pulse closes every legal command. A command whose addressing form is illegal (16-bit effective addressing, or no SIB byte) produces a one-cycle `undef` pulse instead. Such a command issues no requests and no `done`. The block has no fault output: nothing it computes can raise one.

Top module: `vidx_prefetch_agu`

## Requirements
- R1: Each request address equals base + (sign-extended index << scale) + sign-extended displacement, with all arithmetic wrapping modulo 2^64.
- R2: The scale code in `cmd_scale` selects a multiplier of 1, 2, 4 or 8 for codes 0, 1, 2 and 3.
- R3: Variant 0 (dword indices, single-precision) covers 16 lanes. Lane j takes the 32-bit index at bits 32j+31..32j.
- R4: Variants 1 (qword indices, single-precision) and 3 (qword indices, double-precision) cover 8 lanes. Lane j takes the 64-bit index at bits 64j+63..64j.
- R5: Variant 2 (dword indices, double-precision) covers 8 lanes. Lane j takes the 32-bit index at bits 32j+31..32j, so only bits 255..0 are read.
- R6: A request is issued only for lanes whose mask bit is 1, in ascending lane order, with the lane number on `req_lane`. Mask bits 15..8 have no effect in the 8-lane variants.
- R7: Every request carries `req_level` = 2 (second-level cache) and `req_rfo` = 0.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_lane` hold their values. At most one request is transferred per cycle.
- R9: `done` pulses for one cycle in the cycle after the last request transfer. If no lane is active, it pulses in the cycle after acceptance instead.
- R10: If `cmd_addr16` or `cmd_no_sib` is 1 when a command is accepted, `undef` pulses for one cycle in the next cycle. That command issues no requests and no `done`.
- R11: `cmd_ready` is high only when no command is in progress. `cmd_valid` while busy is ignored, and command inputs that change after acceptance do not affect the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted at this edge if valid |
| cmd_variant | input | 2 | 0 dword/single, 1 qword/single, 2 dword/double, 3 qword/double |
| cmd_base | input | 64 | Base address |
| cmd_index | input | 512 | Packed index vector |
| cmd_scale | input | 2 | Scale code (multiplier 1 << code) |
| cmd_disp | input | 32 | Signed displacement |
| cmd_mask | input | 16 | Per-lane enable mask |
| cmd_addr16 | input | 1 | Command uses 16-bit effective addressing |
| cmd_no_sib | input | 1 | Memory operand encoded without a SIB byte |
| req_valid | output | 1 | Prefetch request present |
| req_ready | input | 1 | Request consumer can take it |
| req_addr | output | 64 | Prefetch address |
| req_lane | output | 4 | Lane that produced this request |
| req_level | output | 2 | Cache level hint, always 2 |
| req_rfo | output | 1 | Read-for-ownership flag, always 0 |
| done | output | 1 | One-cycle end-of-command pulse |
| undef | output | 1 | One-cycle illegal-form pulse |

## Verification
The hardest case to reach from the ports is a request held under back-pressure while a second command is offered. The design must freeze its output and ignore the new command, even though every command field has changed. The bench reaches this state by starting a command with `req_ready` held low. On the following cycles it keeps `cmd_valid` high with a different base, index, mask and variant, then releases `req_ready` and compares every address with the first command's values. The vector table also drives irregular ready patterns, so that lanes are skipped and stalls occur in all four variants. One vector uses a base near the top of the address space to exercise wraparound.

// File: rtl/pfgen_pkg.sv
package pfgen_pkg;
  typedef enum logic [1:0] {
    VAR_D_SP = 2'd0,
    VAR_Q_SP = 2'd1,
    VAR_D_DP = 2'd2,
    VAR_Q_DP = 2'd3
  } pf_variant_e;

  localparam logic [1:0] LEVEL_L2 = 2'd2;
  localparam int DWORD_W = 32;
  localparam int QWORD_W = 64;
endpackage

// File: rtl/pfgen_lane_pick.sv
module pfgen_lane_pick #(
  parameter int LANES  = 16,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  pend,
  output logic [LANE_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) idx = LANE_W'(i);
    end
  end
endmodule

// File: rtl/pfgen_addr_calc.sv
module pfgen_addr_calc
  import pfgen_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = $clog2(LANES),
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32,
  localparam int IDX_BITS = LANES * DWORD_W,
  localparam int QLANES   = IDX_BITS / QWORD_W
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [IDX_BITS-1:0] idx_vec,
  input  logic [1:0]          scale,
  input  logic [DISP_W-1:0]   disp,
  input  pf_variant_e         variant,
  input  logic [LANE_W-1:0]   lane,
  output logic [ADDR_W-1:0]   addr
);
  logic [DWORD_W-1:0] dw_arr [LANES];
  logic [QWORD_W-1:0] qw_arr [QLANES];

  for (genvar g = 0; g < LANES; g++) begin : g_dw
    assign dw_arr[g] = idx_vec[g*DWORD_W +: DWORD_W];
  end
  for (genvar g = 0; g < QLANES; g++) begin : g_qw
    assign qw_arr[g] = idx_vec[g*QWORD_W +: QWORD_W];
  end

  logic [DWORD_W-1:0] dw_sel;
  logic [ADDR_W-1:0]  idx_ext, scaled, disp_ext;

  always_comb begin
    dw_sel = dw_arr[lane];
    if (variant == VAR_Q_SP || variant == VAR_Q_DP)
      idx_ext = ADDR_W'(qw_arr[lane[LANE_W-2:0]]);
    else
      idx_ext = {{(ADDR_W-DWORD_W){dw_sel[DWORD_W-1]}}, dw_sel};
    scaled   = idx_ext << scale;
    disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    addr     = base + scaled + disp_ext;
  end
endmodule

// File: rtl/vidx_prefetch_agu.sv
module vidx_prefetch_agu
  import pfgen_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32,
  localparam int LANE_W   = $clog2(LANES),
  localparam int IDX_BITS = LANES * DWORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_variant,
  input  logic [ADDR_W-1:0]   cmd_base,
  input  logic [IDX_BITS-1:0] cmd_index,
  input  logic [1:0]          cmd_scale,
  input  logic [DISP_W-1:0]   cmd_disp,
  input  logic [LANES-1:0]    cmd_mask,
  input  logic                cmd_addr16,
  input  logic                cmd_no_sib,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [LANE_W-1:0]   req_lane,
  output logic [1:0]          req_level,
  output logic                req_rfo,
  output logic                done,
  output logic                undef
);
  localparam logic [LANES-1:0] HALF_EN = {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};

  logic                busy_q, done_q, undef_q;
  logic [LANES-1:0]    pend_q, pend_nxt, lane_en, cmd_act;
  logic [ADDR_W-1:0]   base_q;
  logic [IDX_BITS-1:0] idx_q;
  logic [1:0]          scale_q;
  logic [DISP_W-1:0]   disp_q;
  pf_variant_e         var_q;
  logic [LANE_W-1:0]   pick;
  logic                accept, illegal;

  assign accept  = cmd_valid && !busy_q;
  assign illegal = cmd_addr16 || cmd_no_sib;
  assign lane_en = (pf_variant_e'(cmd_variant) == VAR_D_SP) ? '1 : HALF_EN;
  assign cmd_act = cmd_mask & lane_en;

  pfgen_lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) u_pick (
    .pend (pend_q),
    .idx  (pick)
  );

  pfgen_addr_calc #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_calc (
    .base    (base_q),
    .idx_vec (idx_q),
    .scale   (scale_q),
    .disp    (disp_q),
    .variant (var_q),
    .lane    (pick),
    .addr    (req_addr)
  );

  assign pend_nxt = pend_q & ~(LANES'(1) << pick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      pend_q  <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      scale_q <= '0;
      disp_q  <= '0;
      var_q   <= VAR_D_SP;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      if (accept) begin
        base_q  <= cmd_base;
        idx_q   <= cmd_index;
        scale_q <= cmd_scale;
        disp_q  <= cmd_disp;
        var_q   <= pf_variant_e'(cmd_variant);
        if (illegal) begin
          undef_q <= 1'b1;
        end else if (cmd_act == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          pend_q <= cmd_act;
        end
      end else if (busy_q && req_ready) begin
        pend_q <= pend_nxt;
        if (pend_nxt == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cmd_ready = !busy_q;
  assign req_valid = busy_q;
  assign req_lane  = pick;
  assign req_level = LEVEL_L2;
  assign req_rfo   = 1'b0;
  assign done      = done_q;
  assign undef     = undef_q;
endmodule

// File: rtl/vidx_prefetch_agu_chk.sv
module vidx_prefetch_agu_chk #(
  parameter int ADDR_W = 64,
  parameter int LANE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LANE_W-1:0] req_lane,
  input logic              done,
  input logic              undef
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_lane));

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !req_valid);

  // R6
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || (req_lane > $past(req_lane)));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && !undef);

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past((req_valid && req_ready) || (cmd_valid && cmd_ready)));

  // R10
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> cmd_ready && !req_valid && $past(cmd_valid && cmd_ready));
endmodule

bind vidx_prefetch_agu vidx_prefetch_agu_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_lane  (req_lane),
  .done      (done),
  .undef     (undef)
);

// File: tb/vidx_prefetch_agu_tb.sv
module vidx_prefetch_agu_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [1:0]   cmd_variant = '0;
  logic [63:0]  cmd_base = '0;
  logic [511:0] cmd_index = '0;
  logic [1:0]   cmd_scale = '0;
  logic [31:0]  cmd_disp = '0;
  logic [15:0]  cmd_mask = '0;
  logic         cmd_addr16 = 1'b0;
  logic         cmd_no_sib = 1'b0;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [63:0]  req_addr;
  logic [3:0]   req_lane;
  logic [1:0]   req_level;
  logic         req_rfo;
  logic         done;
  logic         undef;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vidx_prefetch_agu u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_variant(cmd_variant), .cmd_base(cmd_base), .cmd_index(cmd_index),
    .cmd_scale(cmd_scale), .cmd_disp(cmd_disp), .cmd_mask(cmd_mask),
    .cmd_addr16(cmd_addr16), .cmd_no_sib(cmd_no_sib), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_lane(req_lane),
    .req_level(req_level), .req_rfo(req_rfo), .done(done), .undef(undef)
  );

  typedef struct packed {
    logic [1:0]  vsel;
    logic [1:0]  scale;
    logic [15:0] mask;
    logic [31:0] disp;
    logic [63:0] base;
    logic [7:0]  seed;
    logic [3:0]  rdy;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 2'd2, 16'hFFFF, 32'h0000_0010, 64'h0000_0000_1000_0000, 8'd1, 4'hF},
    '{2'd0, 2'd0, 16'hA5C3, 32'hFFFF_FFC0, 64'h0000_7FFF_0000_0000, 8'd2, 4'h5},
    '{2'd1, 2'd3, 16'hFFFF, 32'h0000_0008, 64'h0000_0001_0000_0000, 8'd3, 4'hF},
    '{2'd1, 2'd1, 16'h005A, 32'h0000_0100, 64'h1234_0000_0000_0000, 8'd4, 4'h3},
    '{2'd2, 2'd3, 16'hFFFF, 32'h8000_0000, 64'h0000_0040_0000_0000, 8'd5, 4'hF},
    '{2'd2, 2'd0, 16'h0081, 32'h0000_0004, 64'h0000_0000_0000_0000, 8'd6, 4'h9},
    '{2'd3, 2'd3, 16'h00FF, 32'h0000_0000, 64'h0000_0000_2000_0000, 8'd7, 4'hF},
    '{2'd3, 2'd2, 16'h003C, 32'hFFFF_FFF0, 64'hFFFF_FFFF_FFFF_FF00, 8'd8, 4'h6}
  };

  function automatic logic [511:0] mk_idx(input logic [7:0] seed);
    logic [511:0] v;
    for (int k = 0; k < 16; k++)
      v[k*32 +: 32] = (32'(seed) * 32'h9E37_79B1) + (32'(k) * 32'h1F1F_3C3D);
    return v;
  endfunction

  function automatic logic [63:0] model_addr(input logic [1:0] vs, input logic [63:0] base,
      input logic [511:0] idx, input logic [1:0] sc, input logic [31:0] disp, input int j);
    logic [63:0] ix;
    logic [31:0] w;
    w = idx[j*32 +: 32];
    if (vs == 2'd1 || vs == 2'd3) ix = idx[j*64 +: 64];
    else ix = {{32{w[31]}}, w};
    return base + ix * (64'd1 << sc) + {{32{disp[31]}}, disp};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] vs, input logic [1:0] sc, input logic [15:0] mk,
      input logic [31:0] dp, input logic [63:0] bs, input logic [511:0] ix,
      input bit a16, input bit nosib);
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R11 idle before issue", 64'(cmd_ready), 64'd1);
    cmd_variant = vs; cmd_scale = sc; cmd_mask = mk; cmd_disp = dp;
    cmd_base = bs; cmd_index = ix; cmd_addr16 = a16; cmd_no_sib = nosib;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_addr16 = 1'b0; cmd_no_sib = 1'b0;
  endtask

  // Called at the negedge after acceptance; collects requests until done.
  task automatic collect(input logic [1:0] vs, input logic [1:0] sc, input logic [15:0] mk,
      input logic [31:0] dp, input logic [63:0] bs, input logic [511:0] ix,
      input logic [3:0] rdy, input string tag);
    logic [63:0] ea [16];
    int el [16];
    int ne = 0;
    int got = 0;
    bit seen_done = 1'b0;
    int nl = (vs == 2'd0) ? 16 : 8;
    for (int j = 0; j < nl; j++) begin
      if (mk[j]) begin
        ea[ne] = model_addr(vs, bs, ix, sc, dp, j);
        el[ne] = j;
        ne++;
      end
    end
    for (int c = 0; c < 80 && !seen_done; c++) begin
      req_ready = rdy[c % 4];
      if (done) begin
        seen_done = 1'b1;
        chk(got == ne, {tag, " R9 count at done"}, 64'(got), 64'(ne));
      end else if (req_valid && req_ready) begin
        if (got < ne) begin
          chk(req_addr === ea[got], {tag, " R1 R2 address"}, req_addr, ea[got]);
          chk(32'(req_lane) == el[got], {tag, " R6 lane order"}, 64'(req_lane), 64'(el[got]));
          chk(req_level === 2'd2 && req_rfo === 1'b0, "R7 hint", {req_level, req_rfo}, 64'h4);
        end else begin
          chk(1'b0, {tag, " R6 extra request"}, 64'(req_lane), 64'hFF);
        end
        got++;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
    chk(seen_done, {tag, " R9 done seen"}, 64'(seen_done), 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [511:0] ixa, ixb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R11 R9 R10
    chk(cmd_ready === 1'b1 && req_valid === 1'b0, "R11 reset state", {cmd_ready, req_valid}, 64'h2);
    chk(done === 1'b0 && undef === 1'b0, "R9 R10 reset pulses", {done, undef}, 64'h0);

    // table walk: R3 R4 R5 R1 R2 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      ixa = mk_idx(VEC[v].seed);
      issue(VEC[v].vsel, VEC[v].scale, VEC[v].mask, VEC[v].disp, VEC[v].base, ixa, 1'b0, 1'b0);
      collect(VEC[v].vsel, VEC[v].scale, VEC[v].mask, VEC[v].disp, VEC[v].base, ixa, VEC[v].rdy,
              (VEC[v].vsel == 2'd0) ? "R3" : (VEC[v].vsel == 2'd2) ? "R5" : "R4");
    end

    // R10: 16-bit addressing and missing SIB byte
    for (int f = 0; f < 2; f++) begin
      req_ready = 1'b1;
      issue(2'd0, 2'd0, 16'hFFFF, 32'd0, 64'h100, mk_idx(8'd9), f == 0, f == 1);
      chk(undef === 1'b1 && req_valid === 1'b0 && done === 1'b0, "R10 undef pulse",
          {undef, req_valid, done}, 64'h4);
      @(negedge clk);
      chk(undef === 1'b0 && req_valid === 1'b0 && done === 1'b0 && cmd_ready === 1'b1,
          "R10 no follow-up", {undef, req_valid, done, cmd_ready}, 64'h1);
      req_ready = 1'b0;
    end

    // R9: zero mask; R6: 8-lane variant with only upper mask bits
    issue(2'd0, 2'd1, 16'h0000, 32'd0, 64'h0, mk_idx(8'd10), 1'b0, 1'b0);
    chk(done === 1'b1 && req_valid === 1'b0, "R9 zero mask done", {done, req_valid}, 64'h2);
    issue(2'd1, 2'd1, 16'hFF00, 32'd0, 64'h0, mk_idx(8'd11), 1'b0, 1'b0);
    chk(done === 1'b1 && req_valid === 1'b0, "R6 upper mask ignored", {done, req_valid}, 64'h2);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", 64'(done), 64'd0);

    // R11 + R8: busy command ignored, stall holds request
    ixa = mk_idx(8'd12);
    ixb = mk_idx(8'd13);
    issue(2'd3, 2'd3, 16'h0006, 32'd4, 64'h5000, ixa, 1'b0, 1'b0);
    cmd_variant = 2'd0; cmd_scale = 2'd0; cmd_mask = 16'hFFFF; cmd_disp = 32'd0;
    cmd_base = 64'h9999_0000; cmd_index = ixb; cmd_valid = 1'b1;
    chk(cmd_ready === 1'b0, "R11 busy not ready", 64'(cmd_ready), 64'd0);
    for (int s = 0; s < 3; s++) begin
      chk(req_valid === 1'b1 && req_addr === model_addr(2'd3, 64'h5000, ixa, 2'd3, 32'd4, 1),
          "R8 stalled request held", req_addr, model_addr(2'd3, 64'h5000, ixa, 2'd3, 32'd4, 1));
      @(negedge clk);
    end
    collect(2'd3, 2'd3, 16'h0006, 32'd4, 64'h5000, ixa, 4'hF, "R11 busy ignore");
    cmd_valid = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule